// File: doc/BRIEF.md
# CIC Decimator with Compensation Stage

This block reduces the rate of a signed sample stream by 32 in two steps. A cascaded integrator-comb section built only from adders, subtractors and registers cuts the rate by 16. A 45-tap FIR then flattens the droop that the integrator-comb section puts on the passband, and keeps only every second result, which gives the further factor of two.

Samples arrive with a valid strobe and the block takes one on every cycle where the strobe is high. There is no back-pressure. Each decimated result leaves on a one-cycle output valid pulse. The compensation coefficients are a fixed symmetric set that is computed at elaboration. The overall gain of the integrator-comb section (2^16) and the coefficient scale (2^14) are removed together at the end by one rounding right shift, followed by saturation to the output width.

Top module: `cic_comp_decimator`

## Requirements
- R1: A synchronous active-high reset clears all filter history, the phase counters and the outputs. While reset is high and after it falls, out_valid is 0 and out_data is 0 until 32 new samples have been taken. No sample taken before the reset affects a later output.
- R2: Exactly one output is produced for every 32 accepted samples. out_valid is high for one cycle only, at most 32 clock edges after the edge that accepts the 32nd sample of the group. This holds even when in_valid is held high on every cycle.
- R3: A cycle with in_valid low has no effect: its in_data value changes no output, and it does not advance any phase.
- R4: Counting accepted samples x[n] from n = 0 after reset, decimated integrator-comb value j equals the sum over i = 0..60 of h[i]·x[16j+15−i], with x = 0 before n = 0. Here h holds the coefficients of (1 + z^-1 + … + z^-15)^4. The section registers are 32 bits wide and wrap modulo 2^32.
- R5: Output m equals A_m scaled as in R6. A_m is the sum over k = 0..44 of c[k]·v[2m+1−k], where v is the integrator-comb sequence of R4 and v = 0 before j = 0. The coefficient c[k] depends on d = |k−22|: 20480 when d = 0, −2048 when d = 1, 512 when d = 2, and for d ≥ 3 the value 64 >> floor(d/4), negated when d is odd.
- R6: The scaled value is floor((A_m + 2^29) / 2^30), which is rounding to nearest with halves going toward +infinity.
- R7: Scaled values above 32767 give 32767, and scaled values below −32768 give −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; in_data is taken on every rising edge where this is high |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new decimated sample |
| out_data | output | 16 | Signed, rounded and saturated decimated sample |

## Verification
The hardest case to reach is the compensation stage at full load. This happens when in_valid stays high on every cycle, so the next integrator-comb value is written into the delay RAM while the shared multiply-accumulate is still reading taps for the previous result. The stimulus includes long unbroken runs of valid samples to create this overlap. It also includes a reset in the middle of a group of samples, after which stale RAM words must be masked out because the RAM itself is never cleared. Full-scale DC runs of both signs reach the saturation limits. Randomly gapped traffic, with random data on the idle cycles, shows that those cycles leave no trace in the outputs.

// File: rtl/cicdec_pkg.sv
package cicdec_pkg;

  // Compensation tap value, scaled by 2^14, symmetric about the centre tap.
  function automatic int comp_coef(int k, int taps);
    int d;
    int mag;
    d = k - (taps - 1) / 2;
    if (d < 0) d = -d;
    if (d == 0) return 20480;
    if (d == 1) return -2048;
    if (d == 2) return 512;
    mag = 64 >> (d / 4);
    return (d % 2 == 1) ? -mag : mag;
  endfunction

endpackage

// File: rtl/cicdec_integrators.sv
module cicdec_integrators #(
  parameter int IN_W   = 16,
  parameter int ACC_W  = 32,
  parameter int STAGES = 4,
  parameter int R_LOG2 = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   in_data,
  output logic                     dec_valid,
  output logic signed [ACC_W-1:0]  dec_data
);

  logic [R_LOG2-1:0] phase_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_int
    logic signed [ACC_W-1:0] acc_r;
    logic signed [ACC_W-1:0] sum;
    if (s == 0) begin : g_head
      assign sum = acc_r + ACC_W'(in_data);
    end else begin : g_tail
      assign sum = acc_r + g_int[s-1].sum;
    end
    always_ff @(posedge clk) begin
      if (rst)           acc_r <= '0;
      else if (in_valid) acc_r <= sum;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= '0;
      dec_valid <= 1'b0;
      dec_data  <= '0;
    end else begin
      dec_valid <= 1'b0;
      if (in_valid) begin
        phase_q <= phase_q + 1'b1;
        if (phase_q == '1) begin
          dec_valid <= 1'b1;
          dec_data  <= g_int[STAGES-1].sum;
        end
      end
    end
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase_q)); // R3

endmodule

// File: rtl/cicdec_combs.sv
module cicdec_combs #(
  parameter int ACC_W  = 32,
  parameter int STAGES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     dec_valid,
  input  logic signed [ACC_W-1:0]  dec_data,
  output logic                     cic_valid,
  output logic signed [ACC_W-1:0]  cic_data
);

  for (genvar s = 0; s < STAGES; s++) begin : g_comb
    logic signed [ACC_W-1:0] stage_in;
    logic signed [ACC_W-1:0] dly_r;
    logic signed [ACC_W-1:0] diff;
    if (s == 0) begin : g_head
      assign stage_in = dec_data;
    end else begin : g_tail
      assign stage_in = g_comb[s-1].diff;
    end
    assign diff = stage_in - dly_r;
    always_ff @(posedge clk) begin
      if (rst)            dly_r <= '0;
      else if (dec_valid) dly_r <= stage_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cic_valid <= 1'b0;
      cic_data  <= '0;
    end else begin
      cic_valid <= dec_valid;
      if (dec_valid) cic_data <= g_comb[STAGES-1].diff;
    end
  end

  AST_CIC_PULSE: assert property (@(posedge clk) disable iff (rst)
    cic_valid |=> !cic_valid); // R2

endmodule

// File: rtl/cicdec_comp_fir.sv
module cicdec_comp_fir
  import cicdec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int COEF_W = 16,
  parameter int TAPS   = 45,
  parameter int OUT_W  = 16,
  parameter int SHIFT  = 30
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_data
);

  localparam int HALF   = (TAPS - 1) / 2;
  localparam int AW     = $clog2(TAPS + 1);
  localparam int DEPTH  = 1 << AW;
  localparam int FW     = $clog2(TAPS + 1);
  localparam int KW     = $clog2(HALF + 1);
  localparam int PRE_W  = DATA_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(HALF + 1);
  localparam logic signed [ACC_W-1:0] RND  = {{(ACC_W-1){1'b0}}, 1'b1} << (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] OMAX = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] OMIN = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [COEF_W-1:0] coef_rom [HALF+1];
  for (genvar g = 0; g <= HALF; g++) begin : g_coef
    assign coef_rom[g] = COEF_W'(comp_coef(g, TAPS));
  end

  // Two copies of the delay line give two reads per cycle for the pre-add.
  logic signed [DATA_W-1:0] mem_a [DEPTH];
  logic signed [DATA_W-1:0] mem_b [DEPTH];
  logic signed [DATA_W-1:0] rd_a, rd_b;
  logic [AW-1:0] wptr_q, base_q, raddr_a, raddr_b;
  logic [FW-1:0] fill_q, nfill_q;
  logic [KW-1:0] kidx_q, s1_k;
  logic half_q, busy_q, start;
  logic s1_vld, s1_use_a, s1_use_b;
  logic s2_vld, s2_first, s2_last, s3_done;
  logic signed [PRE_W-1:0]  pre_s;
  logic signed [PROD_W-1:0] prod_q;
  logic signed [ACC_W-1:0]  acc_q, biased, scaled;
  logic signed [OUT_W-1:0]  sat_v;

  assign start   = in_valid && half_q;
  assign raddr_a = base_q - AW'(kidx_q);
  assign raddr_b = base_q - AW'(TAPS - 1) + AW'(kidx_q);

  always_ff @(posedge clk) begin
    if (in_valid) begin
      mem_a[wptr_q] <= in_data;
      mem_b[wptr_q] <= in_data;
    end
    rd_a <= mem_a[raddr_a];
    rd_b <= mem_b[raddr_b];
  end

  always_comb begin
    pre_s  = (s1_use_a ? PRE_W'(rd_a) : '0) + (s1_use_b ? PRE_W'(rd_b) : '0);
    biased = acc_q + RND;
    scaled = biased >>> SHIFT;
    if (scaled > OMAX)      sat_v = OMAX[OUT_W-1:0];
    else if (scaled < OMIN) sat_v = OMIN[OUT_W-1:0];
    else                    sat_v = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0; base_q <= '0; fill_q <= '0; nfill_q <= '0;
      half_q <= 1'b0; busy_q <= 1'b0; kidx_q <= '0;
      s1_vld <= 1'b0; s1_k <= '0; s1_use_a <= 1'b0; s1_use_b <= 1'b0;
      s2_vld <= 1'b0; s2_first <= 1'b0; s2_last <= 1'b0; prod_q <= '0;
      s3_done <= 1'b0; acc_q <= '0;
      out_valid <= 1'b0; out_data <= '0;
    end else begin
      if (in_valid) begin
        wptr_q <= wptr_q + 1'b1;
        half_q <= ~half_q;
        if (fill_q != FW'(TAPS)) fill_q <= fill_q + 1'b1;
      end
      if (start) begin
        busy_q  <= 1'b1;
        base_q  <= wptr_q;
        kidx_q  <= '0;
        nfill_q <= (fill_q == FW'(TAPS)) ? fill_q : fill_q + 1'b1;
      end else if (busy_q) begin
        kidx_q <= kidx_q + 1'b1;
        if (kidx_q == KW'(HALF)) busy_q <= 1'b0;
      end
      // stage 1: taps read from RAM, masked when older than the fill level
      s1_vld   <= busy_q;
      s1_k     <= kidx_q;
      s1_use_a <= int'(kidx_q) < int'(nfill_q);
      s1_use_b <= ((TAPS - 1 - int'(kidx_q)) < int'(nfill_q)) && (kidx_q != KW'(HALF));
      // stage 2: pre-add and multiply
      s2_vld   <= s1_vld;
      s2_first <= (s1_k == '0);
      s2_last  <= (s1_k == KW'(HALF));
      prod_q   <= PROD_W'(pre_s) * PROD_W'(coef_rom[s1_k]);
      // stage 3: accumulate
      s3_done  <= s2_vld && s2_last;
      if (s2_vld) acc_q <= (s2_first ? '0 : acc_q) + ACC_W'(prod_q);
      // stage 4: round, saturate, present
      out_valid <= s3_done;
      if (s3_done) out_data <= sat_v;
    end
  end

  AST_MAC_FREE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q); // R2
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R2
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (s3_done && scaled > OMAX) |=> (out_data == OMAX[OUT_W-1:0])); // R7

endmodule

// File: rtl/cic_comp_decimator.sv
module cic_comp_decimator #(
  parameter int IN_W      = 16,
  parameter int OUT_W     = 16,
  parameter int R_LOG2    = 4,
  parameter int STAGES    = 4,
  parameter int TAPS      = 45,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  localparam int CIC_W = IN_W + STAGES * R_LOG2;
  localparam int SHIFT = STAGES * R_LOG2 + COEF_FRAC;

  logic                    dec_valid, cic_valid;
  logic signed [CIC_W-1:0] dec_data, cic_data;

  cicdec_integrators #(.IN_W(IN_W), .ACC_W(CIC_W), .STAGES(STAGES), .R_LOG2(R_LOG2)) u_int (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .dec_valid(dec_valid), .dec_data(dec_data));

  cicdec_combs #(.ACC_W(CIC_W), .STAGES(STAGES)) u_comb (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_data(dec_data),
    .cic_valid(cic_valid), .cic_data(cic_data));

  cicdec_comp_fir #(.DATA_W(CIC_W), .COEF_W(COEF_W), .TAPS(TAPS), .OUT_W(OUT_W),
                    .SHIFT(SHIFT)) u_fir (
    .clk(clk), .rst(rst), .in_valid(cic_valid), .in_data(cic_data),
    .out_valid(out_valid), .out_data(out_data));

endmodule

// File: tb/cic_comp_decimator_tb_top.sv
`timescale 1ns/1ps
module cic_comp_decimator_tb_top;
  localparam int IN_W = 16;
  localparam int OUT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic out_valid;
  logic signed [OUT_W-1:0] out_data;

  cic_comp_decimator dut_i (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
                            .out_valid(out_valid), .out_data(out_data));

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  string tag = "R4 R5 R6";
  longint h[61];
  longint cf[45];
  int xs[$];
  longint cq[$];
  longint eq[$];
  int eacc[$];
  bit esat[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic build_tables();
    longint p[61];
    int len;
    foreach (p[i]) p[i] = 0;
    p[0] = 1;
    len = 1;
    repeat (4) begin
      longint q[61];
      foreach (q[i]) q[i] = 0;
      for (int i = 0; i < len; i++)
        for (int t = 0; t < 16; t++) q[i+t] += p[i];
      p = q;
      len += 15;
    end
    h = p;
    for (int k = 0; k < 45; k++) begin
      int d;
      int mag;
      d = (k > 22) ? k - 22 : 22 - k;
      if (d == 0) cf[k] = 20480;
      else if (d == 1) cf[k] = -2048;
      else if (d == 2) cf[k] = 512;
      else begin
        mag = 64 >> (d / 4);
        cf[k] = (d % 2 == 1) ? -mag : mag;
      end
    end
  endtask

  task automatic push_sample(input int v, input int acc_edge);
    xs.push_back(v);
    if (xs.size() % 16 == 0) begin
      int j;
      longint s;
      j = xs.size() / 16 - 1;
      s = 0;
      for (int n = 0; n < 61; n++) begin
        int idx;
        idx = 16 * j + 15 - n;
        if (idx >= 0) s += h[n] * longint'(xs[idx]);
      end
      cq.push_back(s);
    end
    if (xs.size() % 32 == 0) begin
      int m;
      longint a;
      longint r;
      m = xs.size() / 32 - 1;
      a = 0;
      for (int k = 0; k < 45; k++) begin
        int idx;
        idx = 2 * m + 1 - k;
        if (idx >= 0) a += cf[k] * cq[idx];
      end
      r = (a + (longint'(1) <<< 29)) >>> 30;
      esat.push_back(r > 32767 || r < -32768);
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      eq.push_back(r);
      eacc.push_back(acc_edge);
    end
  endtask

  task automatic send(input int v, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data = IN_W'($urandom);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data = IN_W'(v);
    push_sample(v, cyc + 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data = IN_W'($urandom);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      if (eq.size() == 0) begin
        chk(1'b0, "R2 unexpected output", longint'(out_data), 0);
      end else begin
        longint e;
        int a;
        bit s;
        e = eq.pop_front();
        a = eacc.pop_front();
        s = esat.pop_front();
        chk(longint'(out_data) == e, s ? "R7 saturated value" : tag, longint'(out_data), e);
        chk((cyc - a) >= 1 && (cyc - a) <= 32, "R2 latency", cyc - a, 32);
      end
    end
  end

  initial begin
    #(200000.0 * 5.0);
    if (!finished) begin
      chk(1'b0, "R2 watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    build_tables();
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    chk(out_data == '0, "R1 out_data in reset", longint'(out_data), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);

    // impulse response through both stages
    tag = "R4 R5 R6 impulse";
    send(1000, 0);
    for (int i = 0; i < 32 * 50 - 1; i++) send(0, 0);
    idle(40);
    chk(eq.size() == 0, "R2 impulse outputs missing", eq.size(), 0);

    // full-scale DC of both signs, continuous valid
    tag = "R5 R6 positive DC";
    for (int i = 0; i < 32 * 60; i++) send(32767, 0);
    tag = "R5 R6 negative DC";
    for (int i = 0; i < 32 * 60; i++) send(-32768, 0);
    idle(40);
    chk(eq.size() == 0, "R2 DC outputs missing", eq.size(), 0);

    // random data with random idle cycles carrying garbage
    tag = "R3 R4 R5 R6 gapped random";
    for (int i = 0; i < 32 * 80; i++)
      send(int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 3)));
    idle(40);
    chk(eq.size() == 0, "R3 gapped outputs missing", eq.size(), 0);

    // square wave with large swings
    tag = "R4 R5 R6 square";
    for (int i = 0; i < 32 * 40; i++) send(((i / 8) % 2 == 1) ? -12000 : 12000, 0);
    idle(40);
    chk(eq.size() == 0, "R2 square outputs missing", eq.size(), 0);

    // reset partway through a group: old history must be gone
    for (int i = 0; i < 20; i++) send(20000, 0);
    idle(2);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in mid reset", longint'(out_valid), 0);
    chk(out_data == '0, "R1 out_data in mid reset", longint'(out_data), 0);
    xs.delete();
    cq.delete();
    rst = 1'b0;
    tag = "R1 history cleared";
    for (int i = 0; i < 32 * 50; i++) send(5000, 0);
    idle(40);
    chk(eq.size() == 0, "R1 post-reset outputs missing", eq.size(), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule